// File: doc/BRIEF.md
# I2C Memory Target with 11-bit Address Counter

This block is an I2C target that gives a bus master access to a 2048-byte memory through a simple synchronous memory port. A faster system clock oversamples the bus lines. Each line passes through a two-flop synchronizer, and edge detection on the synchronized lines yields SCL rise, SCL fall, START and STOP. The block drives SDA only through an open-drain enable (`sda_oe` high pulls the line low). It never stretches the clock.

The first byte after START is the address byte, sent MSB first. It carries a fixed 4-bit prefix `1010` in bits 7..4. Bits 3..1 carry memory-address bits 10..8, and bit 0 selects the direction (1 = read, 0 = write). In a write, the next byte sets memory-address bits 7..0, and every later byte is stored at the current address. In a read, bytes are sent from the current address for as long as the master acknowledges. A random read is a write of the two address bytes, then a repeated START, then a read.

The controller is one state machine with these states:
- `ST_IDLE`: wait for START.
- `ST_DEV`: receive the address byte.
- `ST_DEV_ACK`: acknowledge the address byte.
- `ST_WADDR` and `ST_WADDR_ACK`: receive and acknowledge the low address byte.
- `ST_WDATA` and `ST_WDATA_ACK`: receive, store and acknowledge a data byte.
- `ST_RDATA`: shift out a byte.
- `ST_RACK`: sample the master's acknowledge.
- `ST_WAIT_STOP`: stay silent until the bus is released.

Transitions:
- START from any state goes to `ST_DEV`, and STOP from any state goes to `ST_IDLE`.
- From `ST_DEV`, a prefix match goes to `ST_DEV_ACK` and a mismatch goes to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read or `ST_WADDR` for a write.
- `ST_WADDR_ACK` goes to `ST_WDATA`, and the states `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK`.
- From `ST_RACK`, an acknowledge goes back to `ST_RDATA` and a not-acknowledge goes to `ST_WAIT_STOP`.

Top module: `i2c_mem_target`

## Requirements
- R1: Before the first START, clocked bus traffic gets no acknowledge and causes no memory access.
- R2: An address byte whose bits 7..4 differ from `1010` gets no acknowledge. After it, no byte is acknowledged and no memory access occurs until the next START.
- R3: An address byte whose bits 7..4 equal `1010` is acknowledged: SDA is held low throughout the high phase of the ninth SCL clock.
- R4: A matched address byte loads its bits 3..1 into memory-address bits 10..8. In a write, the next byte loads address bits 7..0.
- R5: In a write, each data byte after the low address byte is acknowledged and written once (`mem_we` for one cycle) at the current address. The address then increments, wrapping from 0x7FF to 0x000.
- R6: In a read, the byte at the current address is driven MSB first. Each bit is stable while SCL is high, and SDA is released during the ninth clock.
- R7: When the master acknowledges a read byte, the next byte comes from the next address. The address increments once per byte sent.
- R8: When the master does not acknowledge, the block stops driving SDA and issues no further reads until START or STOP. A later read continues at the address after the last byte sent.
- R9: STOP returns the block to idle with SDA released. A repeated START at any point restarts address-byte reception.
- R10: `sda_oe` changes only while SCL is low, and `mem_we` and `mem_re` are single-cycle pulses that never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr | output | 11 | Current memory address |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_re | output | 1 | One-cycle read strobe; data expected on the next cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |

## Verification
The main path is tried with writes of several bytes, including a run that crosses the 0x7FF boundary. It is also tried with random reads set up through a repeated START, current-address reads after a NACK, and traffic with no START or a wrong prefix. The writes and the wrap show whether the address counter steps and wraps correctly. The reads with ACK then NACK show whether the prefetch and increment order matches the bytes the master sees. The unaddressed traffic shows that acknowledges and memory strobes depend only on START and the prefix. Every clock, each write strobe is compared against a queue of expected address and data pairs built by a behavioural model of the bus.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
    localparam int MEM_ADDR_W = 11;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // SYNC_STAGES synchronizer flops plus one history flop per line
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];
    assign scl_q = scl_pipe[SYNC_STAGES];
    assign sda_q = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic [ADDR_W-9:0] hi_bits,
    input  logic              ld_lo,
    input  logic [7:0]        lo_bits,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_hi) begin
            addr[ADDR_W-1:8] <= hi_bits;
        end else if (ld_lo) begin
            addr[7:0] <= lo_bits;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = MEM_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    tgt_state_t state, nxt;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sr;
    logic [7:0] tx_sr;
    logic       rw_q;
    logic       re_q;
    logic       byte_done;
    logic       rx_phase;
    logic       wr_evt, rd_evt, ld_hi, ld_lo;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi   (ld_hi),
        .hi_bits (rx_sr[HI_W:1]),
        .ld_lo   (ld_lo),
        .lo_bits (rx_sr),
        .step    (mem_we | mem_re),
        .addr    (mem_addr)
    );

    assign byte_done = (bit_cnt == 4'd8);
    assign rx_phase  = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);

    // next state and single-cycle events
    always_comb begin
        nxt    = state;
        wr_evt = 1'b0;
        rd_evt = 1'b0;
        ld_hi  = 1'b0;
        ld_lo  = 1'b0;
        if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT_STOP: nxt = state;
                ST_DEV: begin
                    if (scl_fall && byte_done) begin
                        if (rx_sr[7:4] == DEV_PREFIX) begin
                            nxt    = ST_DEV_ACK;
                            ld_hi  = 1'b1;
                            rd_evt = rx_sr[0];
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: if (scl_fall) nxt = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR: begin
                    if (scl_fall && byte_done) begin
                        nxt   = ST_WADDR_ACK;
                        ld_lo = 1'b1;
                    end
                end
                ST_WADDR_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_WDATA: begin
                    if (scl_fall && byte_done) begin
                        nxt    = ST_WDATA_ACK;
                        wr_evt = 1'b1;
                    end
                end
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA: if (scl_fall && bit_cnt == 4'd7) nxt = ST_RACK;
                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_s) rd_evt = 1'b1;
                        else        nxt    = ST_WAIT_STOP;
                    end else if (scl_fall) begin
                        nxt = ST_RDATA;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register and datapath bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            rw_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det || nxt != state) begin
                bit_cnt <= '0;
            end else if (rx_phase && scl_rise && !byte_done) begin
                bit_cnt <= bit_cnt + 1'b1;
            end else if (state == ST_RDATA && scl_fall) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (rx_phase && scl_rise && !byte_done) begin
                rx_sr <= {rx_sr[6:0], sda_s};
            end
            if (ld_hi) begin
                rw_q <= rx_sr[0];
            end
        end
    end

    // registered outputs and transmit shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            mem_wdata <= '0;
            re_q      <= 1'b0;
            tx_sr     <= '1;
        end else begin
            mem_we <= wr_evt;
            mem_re <= rd_evt;
            re_q   <= mem_re;
            if (wr_evt) begin
                mem_wdata <= rx_sr;
            end
            if (re_q) begin
                tx_sr <= mem_rdata;
            end else if (state == ST_RDATA && scl_fall && bit_cnt != 4'd7) begin
                tx_sr <= {tx_sr[6:0], 1'b1};
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                               sda_oe = ~tx_sr[7];
            default:                                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_mem_target_props.sv
module i2c_mem_target_props #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          scl_s,
    input logic          stop_det
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_we_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_re_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    assert_write_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr - $past(mem_addr)) == AW'(1));

    assert_read_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mem_addr - $past(mem_addr)) == AW'(1));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind i2c_mem_target i2c_mem_target_props u_props (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .scl_s    (scl_s),
    .stop_det (stop_det)
);

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, mem_we, mem_re;
    logic [10:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    wire sda_line = ~(m_low | sda_oe);

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int model_addr = 0;
    logic [7:0] bmem [0:2047];
    logic [7:0] refm [0:2047];
    logic [18:0] wq[$];

    always #2 clk = ~clk;

    i2c_mem_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model behind the port
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= bmem[mem_addr];
        if (mem_we) bmem[mem_addr] <= mem_wdata;
    end

    // per-clock comparison of write strobes against the reference queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) we_cnt++;
            if (mem_re) re_cnt++;
            if (mem_we && mem_re) chk(0, "R10 strobes together", 1, 0);
            if (mem_we) begin
                if (wq.size() == 0) begin
                    chk(0, "R5 unexpected write", int'(mem_addr), 0);
                end else begin
                    logic [18:0] e;
                    e = wq.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R5 write addr/data",
                        int'({mem_addr, mem_wdata}), int'(e));
                end
            end
        end
    end

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tk(10);
        m_scl = 1'b1; tk(10);
        m_low = 1'b1; tk(10);
        m_scl = 1'b0; tk(10);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tk(10);
        m_scl = 1'b1; tk(10);
        m_low = 1'b0; tk(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tk(10);
            m_scl = 1'b1;  tk(20);
            m_scl = 1'b0;  tk(10);
        end
        m_low = 1'b0; tk(10);
        m_scl = 1'b1; tk(2);
        acked = (sda_line == 1'b0);
        tk(8);
        acked = acked && (sda_line == 1'b0);
        tk(8);
        acked = acked && (sda_line == 1'b0);
        tk(2);
        m_scl = 1'b0; tk(10);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit stable);
        stable = 1'b1;
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic s0;
            tk(10);
            m_scl = 1'b1; tk(3);
            s0 = sda_line; tk(7);
            b[i] = sda_line; tk(8);
            if (sda_line != s0 || b[i] != s0) stable = 1'b0;
            tk(2);
            m_scl = 1'b0;
        end
        tk(10);
        m_low = give_ack; tk(10);
        m_scl = 1'b1; tk(10);
        chk(sda_oe == 1'b0, "R6 released on ninth clock", sda_oe, 0);
        tk(10);
        m_scl = 1'b0; tk(5);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] hi, input bit rd);
        return {4'b1010, hi, rd};
    endfunction

    task automatic write_txn(input logic [2:0] hi, input logic [7:0] lo, input int n, input logic [7:0] seed);
        bit a;
        bus_start();
        send_byte(dev_byte(hi, 0), a);
        chk(a, "R3 address ack (write)", a, 1);
        model_addr = {hi, lo};
        send_byte(lo, a);
        chk(a, "R4 low address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 37);
            wq.push_back({11'(model_addr), d});
            refm[model_addr] = d;
            model_addr = (model_addr + 1) & 11'h7FF;
            send_byte(d, a);
            chk(a, "R5 data ack", a, 1);
        end
    endtask

    task automatic read_cur(input logic [2:0] hi, input int n);
        bit a;
        bit st;
        logic [7:0] got;
        bus_start();
        send_byte(dev_byte(hi, 1), a);
        chk(a, "R3 address ack (read)", a, 1);
        model_addr = {hi, model_addr[7:0]};
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = refm[model_addr];
            model_addr = (model_addr + 1) & 11'h7FF;
            recv_byte(k < n - 1, got, st);
            chk(got == e, (k == 0) ? "R6 first read byte" : "R7 next read byte", got, e);
            chk(st, "R6 bit stable while SCL high", st, 1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit a;
        int we0, re0;
        for (int i = 0; i < 2048; i++) begin
            bmem[i] = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        tk(5);
        rst_n = 1'b1;
        tk(3);
        chk(sda_oe == 0 && mem_we == 0 && mem_re == 0, "R1 reset state",
            {sda_oe, mem_we, mem_re}, 0);

        // R1: traffic without START
        m_scl = 1'b0; tk(10);
        send_byte(8'hA0, a);
        chk(!a, "R1 no ack without START", a, 0);
        send_byte(8'h12, a);
        chk(!a, "R1 no ack without START", a, 0);
        chk(we_cnt == 0 && re_cnt == 0, "R1 no memory access", we_cnt + re_cnt, 0);
        m_scl = 1'b1; tk(10);
        bus_stop();

        // R3 R4 R5: plain multi-byte write
        write_txn(3'b101, 8'hF0, 3, 8'h5A);
        bus_stop();
        // R5: wrap from 0x7FF to 0x000
        write_txn(3'b111, 8'hFE, 3, 8'hC3);
        bus_stop();
        chk(wq.size() == 0, "R5 all writes seen", wq.size(), 0);

        // R4 R6 R7 R9: random read through repeated START
        write_txn(3'b010, 8'h34, 0, 8'h00);
        read_cur(3'b010, 3);
        bus_stop();

        // R8: after NACK, nothing driven and no reads
        write_txn(3'b001, 8'h10, 0, 8'h00);
        read_cur(3'b001, 1);
        re0 = re_cnt;
        for (int i = 0; i < 9; i++) begin
            tk(10); m_scl = 1'b1; tk(10);
            chk(sda_line == 1'b1, "R8 no drive after NACK", sda_line, 1);
            tk(10); m_scl = 1'b0; tk(10);
        end
        chk(re_cnt == re0, "R8 no reads after NACK", re_cnt, re0);
        bus_stop();
        chk(sda_oe == 0, "R9 released after STOP", sda_oe, 0);
        // R8: next read continues after the last byte sent
        read_cur(3'b001, 2);
        bus_stop();

        // R5 readback including wrapped bytes
        write_txn(3'b101, 8'hF0, 0, 8'h00);
        read_cur(3'b101, 3);
        bus_stop();
        write_txn(3'b111, 8'hFF, 0, 8'h00);
        read_cur(3'b111, 1);
        bus_stop();
        write_txn(3'b000, 8'h00, 0, 8'h00);
        read_cur(3'b000, 1);
        bus_stop();

        // R2: prefix mismatch
        we0 = we_cnt;
        re0 = re_cnt;
        bus_start();
        send_byte(8'hB4, a);
        chk(!a, "R2 no ack on wrong prefix", a, 0);
        send_byte(8'hA0, a);
        chk(!a, "R2 silent until START", a, 0);
        send_byte(8'h33, a);
        chk(!a, "R2 silent until START", a, 0);
        chk(we_cnt == we0 && re_cnt == re0, "R2 no memory access",
            we_cnt + re_cnt, we0 + re0);
        bus_stop();

        // R9: STOP mid-write after the address, then repeated START in a write
        write_txn(3'b011, 8'h80, 1, 8'h21);
        write_txn(3'b011, 8'h90, 1, 8'h44);
        bus_stop();
        read_cur(3'b011, 1);
        bus_stop();
        write_txn(3'b011, 8'h80, 0, 8'h00);
        bus_stop();
        read_cur(3'b011, 1);
        bus_stop();
        tk(20);
        chk(wq.size() == 0, "R5 all writes seen", wq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule